// File: doc/BRIEF.md
# Two-Cycle Search Command Decoder

This block sits at the command input of a search-engine device. The host issues a search over two back-to-back command cycles, phase A and then phase B. Each phase carries a 68-bit compare beat on the data bus and a 9-bit command word whose parameter bits mean different things in the two phases. The decoder checks the opcode and the framing and pulls out the parameter fields. It builds the 136-bit comparand from the two beats and issues one registered search request, with a comparand write, in the cycle after phase B. A malformed command gives a one-cycle error pulse and is dropped.

Control is a two-state machine. `ST_IDLE` waits for phase A. `ST_PHASE_B` expects the second beat. There are four named transitions:
- `IDLE->PHASE_B` (accept A): a valid search word with the reserved bit clear.
- `IDLE->IDLE` (reject A): a valid search word with the reserved bit set. This raises an error.
- `PHASE_B->IDLE` (issue): a valid search word arrives in phase B and the request is issued.
- `PHASE_B->IDLE` (abort): phase B does not carry a valid search word. This raises an error.

A non-search word, or any word while command-valid is low, leaves `ST_IDLE` unchanged. Synchronous reset returns the machine to `ST_IDLE`.

Top module: `srch_cmd_decoder`

## Requirements
- R1: While `rst` is high at a clock edge, the following are all 0 after that edge: `req_vld`, `cmp_we`, `err`, every field output and `cmp_wr_data`. Any half-received command is dropped, so the next search word is taken as phase A.
- R2: In `ST_IDLE`, a cycle with `cmd_vld`=1, `cmd[1:0]`=2'b10 and `cmd[2]`=0 is taken as phase A. The machine moves to `ST_PHASE_B`, and no request or error appears after that edge.
- R3: In `ST_IDLE`, a cycle with `cmd_vld`=0, or with `cmd[1:0]` other than 2'b10, has no effect: there is no request, no error and no change of state.
- R4: The request carries the mask-pair index from phase A `cmd[5:3]` on `req_mask_idx`. It carries the result-address prefix from phase A `cmd[8:7]` on `req_addr_pfx`. Phase A `cmd[6]` is ignored.
- R5: The request carries the status-register index from phase B `cmd[8:6]` on `req_stat_idx`. It carries the comparand-pair index from phase B `cmd[5:2]` on `req_cmp_idx`.
- R6: `req_vld` is high for exactly one cycle, the cycle after a phase B that has `cmd_vld`=1 and `cmd[1:0]`=2'b10, with `err` low in that cycle.
- R7: In the same cycle as `req_vld`, `cmp_we` is 1, `cmp_wr_idx` equals `req_cmp_idx`, and `cmp_wr_data` is {phase B beat, phase A beat}, with the phase A beat in bits [67:0].
- R8: A search word in `ST_IDLE` with `cmd[2]`=1 raises `err` for the next cycle. The word is discarded and the machine stays in `ST_IDLE`.
- R9: In `ST_PHASE_B`, if `cmd_vld` is 0 or `cmd[1:0]` is not 2'b10, the block raises `err` for the next cycle and issues no request. It returns to `ST_IDLE`, and that cycle is not taken as a new phase A.
- R10: A new phase A is accepted in the cycle right after a phase B, so back-to-back searches yield one request every two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_vld | input | 1 | Command-valid strobe |
| cmd | input | 9 | Command word: opcode in [1:0], parameters in [8:2] per phase |
| dq | input | 68 | Compare data beat |
| req_vld | output | 1 | One-cycle decoded-request pulse |
| req_mask_idx | output | 3 | Mask register pair index |
| req_stat_idx | output | 3 | Search-status register index |
| req_cmp_idx | output | 4 | Comparand register pair index |
| req_addr_pfx | output | 2 | Bits to place on result address [21:20] on a hit |
| cmp_we | output | 1 | Comparand pair write strobe |
| cmp_wr_idx | output | 4 | Comparand pair written |
| cmp_wr_data | output | 136 | Comparand word, phase B beat high, phase A beat low |
| err | output | 1 | One-cycle framing error pulse |

## Verification
Every output is registered. The request fields, the comparand write and `req_vld` are due one clock edge after the phase B edge. An error is due one edge after the offending cycle, whether that is a phase A with the reserved bit set or a broken phase B. Phase A itself makes no output, so the edge after it must show the outputs still quiet. The bench drives inputs on the falling edge and reads outputs on the falling edge that follows the capturing rising edge. Each result is therefore read exactly one rising edge after its stimulus, and the quiet cycles between stimulus and result are read as well.

// File: rtl/srch_dec_pkg.sv
package srch_dec_pkg;

    localparam int CMD_W     = 9;
    localparam int OP_LO     = 0;
    localparam int OP_W      = 2;
    localparam logic [OP_W-1:0] OP_SEARCH = 2'b10;
    localparam int RSV_BIT   = 2;

    // phase A fields
    localparam int MASK_LO   = 3;
    localparam int MASK_W    = 3;
    localparam int PFX_LO    = 7;
    localparam int PFX_W     = 2;

    // phase B fields
    localparam int CMPI_LO   = 2;
    localparam int CMPI_W    = 4;
    localparam int STAT_LO   = 6;
    localparam int STAT_W    = 3;

    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_PHASE_B = 1'b1
    } srch_state_e;

    typedef struct packed {
        logic [MASK_W-1:0] mask_idx;
        logic [PFX_W-1:0]  pfx;
    } phase_a_t;

    typedef struct packed {
        logic [STAT_W-1:0] stat_idx;
        logic [CMPI_W-1:0] cmp_idx;
    } phase_b_t;

    function automatic phase_a_t split_a(input logic [CMD_W-1:0] c);
        phase_a_t f;
        f.mask_idx = c[MASK_LO +: MASK_W];
        f.pfx      = c[PFX_LO +: PFX_W];
        return f;
    endfunction

    function automatic phase_b_t split_b(input logic [CMD_W-1:0] c);
        phase_b_t f;
        f.stat_idx = c[STAT_LO +: STAT_W];
        f.cmp_idx  = c[CMPI_LO +: CMPI_W];
        return f;
    endfunction

endpackage

// File: rtl/srch_cmd_classify.sv
module srch_cmd_classify
    import srch_dec_pkg::*;
(
    input  logic             cmd_vld,
    input  logic [CMD_W-1:0] cmd,
    output logic             is_search,
    output logic             rsv_set,
    output phase_a_t         fld_a,
    output phase_b_t         fld_b
);

    always_comb begin
        is_search = cmd_vld && (cmd[OP_LO +: OP_W] == OP_SEARCH);
        rsv_set   = cmd[RSV_BIT];
        fld_a     = split_a(cmd);
        fld_b     = split_b(cmd);
    end

endmodule

// File: rtl/srch_phase_fsm.sv
module srch_phase_fsm
    import srch_dec_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic is_search,
    input  logic rsv_set,
    output logic cap_a,
    output logic issue,
    output logic fault,
    output logic in_phase_b
);

    srch_state_e state_q;
    srch_state_e state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cap_a   = 1'b0;
        issue   = 1'b0;
        fault   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (is_search) begin
                    if (rsv_set) begin
                        fault   = 1'b1;          // reject A
                    end else begin
                        cap_a   = 1'b1;          // accept A
                        state_d = ST_PHASE_B;
                    end
                end
            end
            ST_PHASE_B: begin
                if (is_search) begin
                    issue = 1'b1;                // issue
                end else begin
                    fault = 1'b1;                // abort
                end
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign in_phase_b = (state_q == ST_PHASE_B);

endmodule

// File: rtl/srch_beat_hold.sv
module srch_beat_hold
    import srch_dec_pkg::*;
#(
    parameter int DATA_W = 68
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_a,
    input  phase_a_t          fld_a,
    input  logic [DATA_W-1:0] dq,
    output phase_a_t          held_a,
    output logic [DATA_W-1:0] held_beat
);

    always_ff @(posedge clk) begin
        if (rst) begin
            held_a    <= '0;
            held_beat <= '0;
        end else if (cap_a) begin
            held_a    <= fld_a;
            held_beat <= dq;
        end
    end

endmodule

// File: rtl/srch_req_out.sv
module srch_req_out
    import srch_dec_pkg::*;
#(
    parameter int DATA_W = 68,
    localparam int WORD_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue,
    input  logic              fault,
    input  phase_a_t          held_a,
    input  logic [DATA_W-1:0] held_beat,
    input  phase_b_t          fld_b,
    input  logic [DATA_W-1:0] dq,
    output logic              req_vld,
    output logic [MASK_W-1:0] req_mask_idx,
    output logic [STAT_W-1:0] req_stat_idx,
    output logic [CMPI_W-1:0] req_cmp_idx,
    output logic [PFX_W-1:0]  req_addr_pfx,
    output logic              cmp_we,
    output logic [CMPI_W-1:0] cmp_wr_idx,
    output logic [WORD_W-1:0] cmp_wr_data,
    output logic              err
);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_vld <= 1'b0;
            cmp_we  <= 1'b0;
            err     <= 1'b0;
        end else begin
            req_vld <= issue;
            cmp_we  <= issue;
            err     <= fault;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_mask_idx <= '0;
            req_addr_pfx <= '0;
            req_stat_idx <= '0;
            req_cmp_idx  <= '0;
            cmp_wr_idx   <= '0;
            cmp_wr_data  <= '0;
        end else if (issue) begin
            req_mask_idx <= held_a.mask_idx;
            req_addr_pfx <= held_a.pfx;
            req_stat_idx <= fld_b.stat_idx;
            req_cmp_idx  <= fld_b.cmp_idx;
            cmp_wr_idx   <= fld_b.cmp_idx;
            cmp_wr_data  <= {dq, held_beat};
        end
    end

endmodule

// File: rtl/srch_cmd_decoder.sv
module srch_cmd_decoder
    import srch_dec_pkg::*;
#(
    parameter int DATA_W = 68,
    localparam int WORD_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_vld,
    input  logic [CMD_W-1:0]  cmd,
    input  logic [DATA_W-1:0] dq,
    output logic              req_vld,
    output logic [MASK_W-1:0] req_mask_idx,
    output logic [STAT_W-1:0] req_stat_idx,
    output logic [CMPI_W-1:0] req_cmp_idx,
    output logic [PFX_W-1:0]  req_addr_pfx,
    output logic              cmp_we,
    output logic [CMPI_W-1:0] cmp_wr_idx,
    output logic [WORD_W-1:0] cmp_wr_data,
    output logic              err
);

    logic              is_search;
    logic              rsv_set;
    phase_a_t          fld_a;
    phase_b_t          fld_b;
    logic              cap_a;
    logic              issue;
    logic              fault;
    logic              in_phase_b;
    phase_a_t          held_a;
    logic [DATA_W-1:0] held_beat;
    logic              in_phase_b_unused;

    srch_cmd_classify u_classify (
        .cmd_vld   (cmd_vld),
        .cmd       (cmd),
        .is_search (is_search),
        .rsv_set   (rsv_set),
        .fld_a     (fld_a),
        .fld_b     (fld_b)
    );

    srch_phase_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .is_search  (is_search),
        .rsv_set    (rsv_set),
        .cap_a      (cap_a),
        .issue      (issue),
        .fault      (fault),
        .in_phase_b (in_phase_b)
    );

    srch_beat_hold #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .cap_a     (cap_a),
        .fld_a     (fld_a),
        .dq        (dq),
        .held_a    (held_a),
        .held_beat (held_beat)
    );

    srch_req_out #(.DATA_W(DATA_W)) u_out (
        .clk          (clk),
        .rst          (rst),
        .issue        (issue),
        .fault        (fault),
        .held_a       (held_a),
        .held_beat    (held_beat),
        .fld_b        (fld_b),
        .dq           (dq),
        .req_vld      (req_vld),
        .req_mask_idx (req_mask_idx),
        .req_stat_idx (req_stat_idx),
        .req_cmp_idx  (req_cmp_idx),
        .req_addr_pfx (req_addr_pfx),
        .cmp_we       (cmp_we),
        .cmp_wr_idx   (cmp_wr_idx),
        .cmp_wr_data  (cmp_wr_data),
        .err          (err)
    );

    // phase flag is observed by the bound checker
    assign in_phase_b_unused = in_phase_b;

endmodule

// File: rtl/srch_cmd_decoder_chk.sv
module srch_cmd_decoder_chk
    import srch_dec_pkg::*;
#(
    parameter int DATA_W = 68,
    localparam int WORD_W = 2 * DATA_W
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_vld,
    input logic [CMD_W-1:0]  cmd,
    input logic [DATA_W-1:0] dq,
    input logic              req_vld,
    input logic [MASK_W-1:0] req_mask_idx,
    input logic [STAT_W-1:0] req_stat_idx,
    input logic [CMPI_W-1:0] req_cmp_idx,
    input logic [PFX_W-1:0]  req_addr_pfx,
    input logic              cmp_we,
    input logic [CMPI_W-1:0] cmp_wr_idx,
    input logic [WORD_W-1:0] cmp_wr_data,
    input logic              err,
    input logic              in_phase_b
);

    logic srch_word;
    assign srch_word = cmd_vld && (cmd[1:0] == 2'b10);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!req_vld && !cmp_we && !err && !in_phase_b));

    assert_accept_a_R2: assert property (@(posedge clk) disable iff (rst)
        (!in_phase_b && srch_word && !cmd[2]) |=> (in_phase_b && !req_vld && !err));

    assert_ignore_idle_R3: assert property (@(posedge clk) disable iff (rst)
        (!in_phase_b && !srch_word) |=> (!in_phase_b && !req_vld && !err));

    assert_fields_a_R4: assert property (@(posedge clk) disable iff (rst)
        req_vld |-> (req_mask_idx == $past(cmd[5:3], 2) && req_addr_pfx == $past(cmd[8:7], 2)));

    assert_fields_b_R5: assert property (@(posedge clk) disable iff (rst)
        req_vld |-> (req_stat_idx == $past(cmd[8:6]) && req_cmp_idx == $past(cmd[5:2])));

    assert_issue_R6: assert property (@(posedge clk) disable iff (rst)
        (in_phase_b && srch_word) |=> (req_vld && !err));

    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        req_vld |=> !req_vld);

    assert_cmp_write_R7: assert property (@(posedge clk) disable iff (rst)
        req_vld |-> (cmp_we && cmp_wr_idx == req_cmp_idx
                     && cmp_wr_data == {$past(dq), $past(dq, 2)}));

    assert_we_only_with_req_R7: assert property (@(posedge clk) disable iff (rst)
        cmp_we |-> req_vld);

    assert_reject_a_R8: assert property (@(posedge clk) disable iff (rst)
        (!in_phase_b && srch_word && cmd[2]) |=> (err && !in_phase_b && !req_vld));

    assert_abort_b_R9: assert property (@(posedge clk) disable iff (rst)
        (in_phase_b && !srch_word) |=> (err && !in_phase_b && !req_vld));

    assert_back_to_back_R10: assert property (@(posedge clk) disable iff (rst)
        (in_phase_b && srch_word) |=> !in_phase_b);

endmodule

bind srch_cmd_decoder srch_cmd_decoder_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cmd_vld      (cmd_vld),
    .cmd          (cmd),
    .dq           (dq),
    .req_vld      (req_vld),
    .req_mask_idx (req_mask_idx),
    .req_stat_idx (req_stat_idx),
    .req_cmp_idx  (req_cmp_idx),
    .req_addr_pfx (req_addr_pfx),
    .cmp_we       (cmp_we),
    .cmp_wr_idx   (cmp_wr_idx),
    .cmp_wr_data  (cmp_wr_data),
    .err          (err),
    .in_phase_b   (in_phase_b)
);

// File: tb/srch_cmd_decoder_tb.sv
module srch_cmd_decoder_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;

    // vector fields: [11:10] prefix, [9:7] mask idx, [6:4] status idx, [3:0] comparand idx
    localparam logic [11:0] VEC [NVEC] = '{
        {2'b00, 3'd0, 3'd0, 4'd0},
        {2'b11, 3'd7, 3'd7, 4'd15},
        {2'b01, 3'd5, 3'd2, 4'd9},
        {2'b10, 3'd2, 3'd5, 4'd6},
        {2'b01, 3'd3, 3'd6, 4'd1},
        {2'b10, 3'd6, 3'd1, 4'd12}
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          cmd_vld;
    logic [8:0]    cmd;
    logic [67:0]   dq;
    logic          req_vld;
    logic [2:0]    req_mask_idx;
    logic [2:0]    req_stat_idx;
    logic [3:0]    req_cmp_idx;
    logic [1:0]    req_addr_pfx;
    logic          cmp_we;
    logic [3:0]    cmp_wr_idx;
    logic [135:0]  cmp_wr_data;
    logic          err;

    int n_chk  = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    srch_cmd_decoder u_dut (
        .clk          (clk),
        .rst          (rst),
        .cmd_vld      (cmd_vld),
        .cmd          (cmd),
        .dq           (dq),
        .req_vld      (req_vld),
        .req_mask_idx (req_mask_idx),
        .req_stat_idx (req_stat_idx),
        .req_cmp_idx  (req_cmp_idx),
        .req_addr_pfx (req_addr_pfx),
        .cmp_we       (cmp_we),
        .cmp_wr_idx   (cmp_wr_idx),
        .cmp_wr_data  (cmp_wr_data),
        .err          (err)
    );

    task automatic chk(input string tag, input logic [135:0] act, input logic [135:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // phase A word: cmd[8:7] prefix, cmd[6] don't care (driven 1), cmd[5:3] mask, cmd[2]=rsv, cmd[1:0]=10
    function automatic logic [8:0] word_a(input logic [11:0] v, input logic rsv);
        return {v[11:10], 1'b1, v[9:7], rsv, 2'b10};
    endfunction

    // phase B word: cmd[8:6] status idx, cmd[5:2] comparand idx, cmd[1:0]=10
    function automatic logic [8:0] word_b(input logic [11:0] v);
        return {v[6:4], v[3:0], 2'b10};
    endfunction

    function automatic logic [67:0] beat(input int k);
        return {4'(k), 32'hC0DE0000 | 32'(k), 32'(k) * 32'h01010101};
    endfunction

    task automatic put(input logic v, input logic [8:0] c, input logic [67:0] d);
        @(negedge clk);
        cmd_vld = v;
        cmd     = c;
        dq      = d;
    endtask

    task automatic idle();
        put(1'b0, 9'h000, 68'h0);
    endtask

    task automatic check_req(input logic [11:0] v, input logic [67:0] a, input logic [67:0] b);
        chk("R6 req_vld",       136'(req_vld), 136'(1'b1));
        chk("R6 err",           136'(err), 136'(1'b0));
        chk("R4 mask idx",      136'(req_mask_idx), 136'(v[9:7]));
        chk("R4 addr prefix",   136'(req_addr_pfx), 136'(v[11:10]));
        chk("R5 status idx",    136'(req_stat_idx), 136'(v[6:4]));
        chk("R5 comparand idx", 136'(req_cmp_idx), 136'(v[3:0]));
        chk("R7 cmp_we",        136'(cmp_we), 136'(1'b1));
        chk("R7 cmp_wr_idx",    136'(cmp_wr_idx), 136'(v[3:0]));
        chk("R7 cmp_wr_data",   cmp_wr_data, {b, a});
    endtask

    task automatic quiet(input string tag);
        chk(tag, 136'({req_vld, cmp_we, err}), 136'(3'b000));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R6 watchdog act=timeout exp=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cmd_vld = 1'b0; cmd = '0; dq = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        quiet("R1 reset outputs");
        chk("R1 reset data", cmp_wr_data, 136'(0));
        chk("R1 reset fields", 136'({req_mask_idx, req_stat_idx, req_cmp_idx, req_addr_pfx, cmp_wr_idx}), 136'(0));
        rst = 1'b0;

        // table walk: one search per vector
        for (int i = 0; i < NVEC; i++) begin
            put(1'b1, word_a(VEC[i], 1'b0), beat(2 * i));
            put(1'b1, word_b(VEC[i]), beat(2 * i + 1));
            quiet("R2 no output after phase A");
            idle();
            check_req(VEC[i], beat(2 * i), beat(2 * i + 1));
            idle();
            quiet("R6 pulse ends");
        end

        // R3: non-search words and idle-valid words are ignored
        put(1'b1, 9'b000000001, 68'h1);
        put(1'b1, 9'b000000011, 68'h2);
        quiet("R3 opcode 01 ignored");
        put(1'b1, 9'b000000000, 68'h3);
        quiet("R3 opcode 11 ignored");
        put(1'b0, word_a(VEC[2], 1'b0), 68'h4);
        quiet("R3 opcode 00 ignored");
        put(1'b1, word_a(VEC[3], 1'b0), beat(40));
        quiet("R3 invalid strobe ignored");
        put(1'b1, word_b(VEC[3]), beat(41));
        quiet("R3 state stayed idle");
        idle();
        check_req(VEC[3], beat(40), beat(41));

        // R8: reserved bit set in phase A
        put(1'b1, word_a(VEC[1], 1'b1), beat(50));
        idle();
        chk("R8 err raised", 136'({err, req_vld}), 136'(2'b10));
        idle();
        chk("R8 err one cycle", 136'(err), 136'(1'b0));
        put(1'b1, word_a(VEC[4], 1'b0), beat(51));
        put(1'b1, word_b(VEC[4]), beat(52));
        chk("R8 discarded, next A fresh", 136'(req_vld), 136'(1'b0));
        idle();
        check_req(VEC[4], beat(51), beat(52));

        // R9: phase B drops the strobe
        put(1'b1, word_a(VEC[5], 1'b0), beat(60));
        put(1'b0, word_b(VEC[5]), beat(61));
        idle();
        chk("R9 strobe drop err", 136'({err, req_vld, cmp_we}), 136'(3'b100));
        // R9: phase B with wrong opcode, then a search word must act as phase A
        put(1'b1, word_a(VEC[2], 1'b0), beat(62));
        put(1'b1, 9'b000000011, beat(63));
        put(1'b1, word_a(VEC[1], 1'b0), beat(64));
        chk("R9 opcode drop err", 136'({err, req_vld}), 136'(2'b10));
        put(1'b1, word_b(VEC[1]), beat(65));
        chk("R9 returned to idle", 136'({err, req_vld}), 136'(2'b00));
        idle();
        check_req(VEC[1], beat(64), beat(65));

        // R10: back-to-back searches
        put(1'b1, word_a(VEC[2], 1'b0), beat(70));
        put(1'b1, word_b(VEC[2]), beat(71));
        put(1'b1, word_a(VEC[5], 1'b0), beat(72));
        check_req(VEC[2], beat(70), beat(71));
        put(1'b1, word_b(VEC[5]), beat(73));
        chk("R10 gap cycle", 136'({req_vld, err}), 136'(2'b00));
        idle();
        check_req(VEC[5], beat(72), beat(73));
        chk("R10 second data", cmp_wr_data, {beat(73), beat(72)});

        // R1: reset in the middle of a command
        put(1'b1, word_a(VEC[1], 1'b0), beat(80));
        @(negedge clk);
        rst = 1'b1; cmd_vld = 1'b0; cmd = '0; dq = '0;
        @(negedge clk);
        rst = 1'b0;
        quiet("R1 reset mid-command");
        put(1'b1, word_a(VEC[3], 1'b0), beat(81));
        put(1'b1, word_b(VEC[3]), beat(82));
        chk("R1 pending A dropped", 136'({req_vld, err}), 136'(2'b00));
        idle();
        check_req(VEC[3], beat(81), beat(82));

        idle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule